// File: doc/BRIEF.md
# Supervisor Trap and Return Control Registers

This block holds the supervisor-level control registers of a small core that runs code in a user mode and a supervisor mode. When the instruction at the trap stage is an environment call, raises some other synchronous exception, or is overtaken by an interrupt, the block saves that instruction's address, records a cause code, stacks the current privilege and interrupt-enable state in the status register, and steers fetch to the handler address held in the vector register. All of this happens in the same cycle: the redirect is combinational, and the register updates land at the next clock edge.

A supervisor-return instruction undoes the stacking. It drops the core to the privilege saved in status, restores the interrupt enable, and steers fetch back to the saved exception address. Because that address points at the environment call itself, handler software adds 4 before returning. The same block gives the core read, write and swap access to five registers: status, vector, scratch, exception PC and cause. Every write returns the old value in the same cycle, so a handler can exchange its user and kernel stack pointers through the scratch register with a single instruction.

Top module: `trap_csr_unit`

## Requirements
- R1: When an environment call is presented without another exception, redirect is 1 and redirectPc equals the vector register in that cycle. After the clock edge, the exception PC register holds curPc, which is the address of the call itself.
- R2: The cause register takes the value 8 for an environment call made from user mode and 9 for one made from supervisor mode. Any other synchronous exception writes its excCode instead and has priority over an environment call in the same cycle.
- R3: On every trap entry, status bit 8 (previous privilege, 0 = user, 1 = supervisor) takes the prior mode and status bit 5 (previous enable) takes status bit 1 (interrupt enable). Bit 1 is then cleared and the mode becomes supervisor (privMode = 1).
- R4: A supervisor return made in supervisor mode drives redirect = 1 and redirectPc equal to the exception PC register. After the edge, privMode takes bit 8, bit 1 takes bit 5, bit 5 becomes 1 and bit 8 becomes 0.
- R5: A supervisor return made in user mode is an illegal instruction. It traps to the vector with cause 2 and the return's own address saved.
- R6: A pending interrupt is taken in a cycle with no exception, environment call or return, provided the mode is user or status bit 1 is set. The cause is the top bit (bit XLEN-1) set, with irqCode in the low bits, and the exception PC is curPc. A CSR write presented in that cycle is dropped.
- R7: An interrupt requested while it cannot be taken (a synchronous trap or a return in the same cycle, or interrupts disabled) stays pending. It is taken in the first later cycle where R6 allows it.
- R8: CSR addresses are: 0x100 status, 0x105 vector, 0x140 scratch, 0x141 exception PC, 0x142 cause. csrRdata always shows the addressed register's current value. With csrWrite = 1 the new value is stored at the edge, so a write is a one-cycle swap.
- R9: The two low bits of the vector register always read 0, whatever value is written.
- R10: Only status bits 1, 5 and 8 are writable, and all other status bits read 0. Any address not listed in R8 reads 0 and ignores writes.
- R11: A CSR write presented in the same cycle as a trap entry or a return is dropped.
- R12: After reset the mode is supervisor and all five registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curPc | input | XLEN | Address of the instruction at the trap stage |
| excValid | input | 1 | Synchronous exception other than an environment call |
| excCode | input | 4 | Cause code for excValid |
| ecallValid | input | 1 | Environment-call instruction present |
| sretValid | input | 1 | Supervisor-return instruction present |
| irqReq | input | 1 | Interrupt request pulse |
| irqCode | input | 4 | Interrupt cause code, latched with irqReq |
| csrValid | input | 1 | CSR access present |
| csrWrite | input | 1 | CSR access also writes csrWdata |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | Current value of the addressed CSR |
| redirect | output | 1 | Fetch must go to redirectPc |
| redirectPc | output | XLEN | Handler address or return address |
| privMode | output | 1 | Current mode, 1 = supervisor, 0 = user |

## Verification
On every cycle, the assertions check the following:
- An environment call saves its own address, and one made from user mode records cause 8.
- Every entry stacks the privilege and enable bits correctly.
- A legal return targets the saved PC and restores the stacked mode.
- A return made in user mode records cause 2.
- An interrupt that coincides with a synchronous trap never reaches the cause register in that cycle.

Some behaviour shows only across the bench's sequences. One case is an interrupt that has been held pending through a disabled period or a return and is later taken with its latched code. Others are dropped CSR writes, the masking of status and vector bits, and swap readback.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 12'h100;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR  = 12'h105;
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 12'h140;
  localparam logic [ADDR_W-1:0] ADDR_EPC     = 12'h141;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE   = 12'h142;

  // status bit positions decoded by software
  localparam int BIT_IE     = 1;
  localparam int BIT_PREVIE = 5;
  localparam int BIT_PREVPR = 8;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 4'd2;
  localparam logic [CODE_W-1:0] CODE_CALL_U  = 4'd8;
  localparam logic [CODE_W-1:0] CODE_CALL_S  = 4'd9;

  typedef struct packed {
    logic              enter;   // take a trap this cycle
    logic              leave;   // legal supervisor return
    logic              csrWe;   // commit CSR write
    logic              isInt;   // entry is an interrupt
    logic [CODE_W-1:0] code;    // cause code for entry
  } trapCtl_t;
endpackage

// File: rtl/trap_csr_ctrl.sv
module trap_csr_ctrl
  import trap_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              ecallValid,
  input  logic              sretValid,
  input  logic              irqReq,
  input  logic [CODE_W-1:0] irqCode,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic              privS,
  input  logic              ieQ,
  output trapCtl_t          ctl
);
  logic              irqPend;
  logic [CODE_W-1:0] pendCode;
  logic              callTake, retAny, retBad, syncEvt;
  logic              irqAvail, irqTake;
  logic [CODE_W-1:0] irqCodeEff;

  always_comb begin
    callTake   = ecallValid && !excValid;
    retAny     = sretValid && !excValid && !ecallValid;
    retBad     = retAny && !privS;
    syncEvt    = excValid || ecallValid || sretValid;
    irqAvail   = irqPend || irqReq;
    irqCodeEff = irqReq ? irqCode : pendCode;
    irqTake    = irqAvail && (!privS || ieQ) && !syncEvt;

    ctl.enter = excValid || callTake || retBad || irqTake;
    ctl.leave = retAny && privS;
    ctl.isInt = irqTake;
    if (excValid)      ctl.code = excCode;
    else if (callTake) ctl.code = privS ? CODE_CALL_S : CODE_CALL_U;
    else if (retBad)   ctl.code = CODE_ILLEGAL;
    else               ctl.code = irqCodeEff;
    ctl.csrWe = csrValid && csrWrite && !ctl.enter && !ctl.leave;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPend  <= 1'b0;
      pendCode <= '0;
    end else begin
      irqPend  <= irqAvail && !irqTake;
      pendCode <= irqCodeEff;
    end
  end
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapCtl_t          ctl,
  input  logic [XLEN-1:0]   curPc,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              redirect,
  output logic [XLEN-1:0]   redirectPc,
  output logic              privS,
  output logic              ieQ,
  output logic              prevIeQ,
  output logic              prevPrQ,
  output logic [XLEN-1:0]   vecQ,
  output logic [XLEN-1:0]   epcQ,
  output logic [XLEN-1:0]   causeQ
);
  localparam int PAD_W = XLEN - 1 - CODE_W;

  logic [XLEN-1:0] scratchQ;
  logic [XLEN-1:0] statusRd;

  always_comb begin
    statusRd             = '0;
    statusRd[BIT_IE]     = ieQ;
    statusRd[BIT_PREVIE] = prevIeQ;
    statusRd[BIT_PREVPR] = prevPrQ;
    unique case (csrAddr)
      ADDR_STATUS:  csrRdata = statusRd;
      ADDR_VECTOR:  csrRdata = vecQ;
      ADDR_SCRATCH: csrRdata = scratchQ;
      ADDR_EPC:     csrRdata = epcQ;
      ADDR_CAUSE:   csrRdata = causeQ;
      default:      csrRdata = '0;
    endcase
    redirect   = ctl.enter || ctl.leave;
    redirectPc = ctl.enter ? vecQ : epcQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privS    <= 1'b1;
      ieQ      <= 1'b0;
      prevIeQ  <= 1'b0;
      prevPrQ  <= 1'b0;
      vecQ     <= '0;
      epcQ     <= '0;
      causeQ   <= '0;
      scratchQ <= '0;
    end else if (ctl.enter) begin
      epcQ    <= curPc;
      causeQ  <= {ctl.isInt, {PAD_W{1'b0}}, ctl.code};
      prevPrQ <= privS;
      prevIeQ <= ieQ;
      ieQ     <= 1'b0;
      privS   <= 1'b1;
    end else if (ctl.leave) begin
      privS   <= prevPrQ;
      ieQ     <= prevIeQ;
      prevIeQ <= 1'b1;
      prevPrQ <= 1'b0;
    end else if (ctl.csrWe) begin
      unique case (csrAddr)
        ADDR_STATUS: begin
          ieQ     <= csrWdata[BIT_IE];
          prevIeQ <= csrWdata[BIT_PREVIE];
          prevPrQ <= csrWdata[BIT_PREVPR];
        end
        ADDR_VECTOR:  vecQ     <= {csrWdata[XLEN-1:2], 2'b00};
        ADDR_SCRATCH: scratchQ <= csrWdata;
        ADDR_EPC:     epcQ     <= csrWdata;
        ADDR_CAUSE:   causeQ   <= csrWdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
  import trap_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [XLEN-1:0]   curPc,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              ecallValid,
  input  logic              sretValid,
  input  logic              irqReq,
  input  logic [CODE_W-1:0] irqCode,
  input  logic              csrValid,
  input  logic              csrWrite,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              redirect,
  output logic [XLEN-1:0]   redirectPc,
  output logic              privMode
);
  trapCtl_t        ctl;
  logic            privS, ieQ, prevIeQ, prevPrQ;
  logic [XLEN-1:0] vecQ, epcQ, causeQ;

  trap_csr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
    .ecallValid(ecallValid), .sretValid(sretValid), .irqReq(irqReq),
    .irqCode(irqCode), .csrValid(csrValid), .csrWrite(csrWrite),
    .privS(privS), .ieQ(ieQ), .ctl(ctl)
  );

  trap_csr_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curPc(curPc), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .redirect(redirect),
    .redirectPc(redirectPc), .privS(privS), .ieQ(ieQ), .prevIeQ(prevIeQ),
    .prevPrQ(prevPrQ), .vecQ(vecQ), .epcQ(epcQ), .causeQ(causeQ)
  );

  assign privMode = privS;
endmodule

// File: rtl/trap_csr_checker.sv
module trap_csr_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [XLEN-1:0] curPc,
  input logic            excValid,
  input logic            ecallValid,
  input logic            sretValid,
  input logic            irqReq,
  input logic            redirect,
  input logic [XLEN-1:0] redirectPc,
  input logic            privMode,
  input logic            ieQ,
  input logic            prevIeQ,
  input logic            prevPrQ,
  input logic [XLEN-1:0] epcQ,
  input logic [XLEN-1:0] causeQ
);
  logic retSlot, legalRet;
  assign retSlot  = sretValid && !excValid && !ecallValid;
  assign legalRet = retSlot && privMode;

  // R1: the call's own address is saved
  a_r1_epc_is_call: assert property (@(posedge clk) disable iff (!rstN)
    (ecallValid && !excValid) |=> epcQ == $past(curPc));

  // R2: user-mode call cause
  a_r2_user_call_cause: assert property (@(posedge clk) disable iff (!rstN)
    (ecallValid && !excValid && !privMode) |=> causeQ == XLEN'(8));

  // R3: entry stacks privilege and enable
  a_r3_entry_stack: assert property (@(posedge clk) disable iff (!rstN)
    (redirect && !legalRet) |=> (privMode && !ieQ && prevIeQ == $past(ieQ)
                                 && prevPrQ == $past(privMode)));

  // R4: legal return targets saved PC
  a_r4_ret_target: assert property (@(posedge clk) disable iff (!rstN)
    legalRet |-> (redirect && redirectPc == epcQ));

  // R4: legal return restores stacked mode
  a_r4_ret_mode: assert property (@(posedge clk) disable iff (!rstN)
    legalRet |=> (privMode == $past(prevPrQ) && ieQ == $past(prevIeQ)));

  // R5: return from user mode is illegal
  a_r5_user_ret_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (retSlot && !privMode) |=> (causeQ == XLEN'(2) && privMode));

  // R7: interrupt coinciding with a synchronous trap is not taken then
  a_r7_irq_deferred: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && (excValid || ecallValid)) |=> !causeQ[XLEN-1]);
endmodule

bind trap_csr_unit trap_csr_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rstN(rstN), .curPc(curPc), .excValid(excValid),
  .ecallValid(ecallValid), .sretValid(sretValid), .irqReq(irqReq),
  .redirect(redirect), .redirectPc(redirectPc), .privMode(privMode),
  .ieQ(ieQ), .prevIeQ(prevIeQ), .prevPrQ(prevPrQ), .epcQ(epcQ),
  .causeQ(causeQ)
);

// File: tb/trap_csr_unit_test.sv
module trap_csr_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ST = 12'h100, A_VEC = 12'h105, A_SCR = 12'h140,
                          A_EPC = 12'h141, A_CAU = 12'h142, A_BAD = 12'h7C0;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] curPc;
  logic        excValid, ecallValid, sretValid, irqReq, csrValid, csrWrite;
  logic [3:0]  excCode, irqCode;
  logic [11:0] csrAddr;
  logic [31:0] csrWdata, csrRdata, redirectPc;
  logic        redirect, privMode;
  int          checks = 0;
  int          fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_csr_unit uut (
    .clk(clk), .rstN(rstN), .curPc(curPc), .excValid(excValid),
    .excCode(excCode), .ecallValid(ecallValid), .sretValid(sretValid),
    .irqReq(irqReq), .irqCode(irqCode), .csrValid(csrValid),
    .csrWrite(csrWrite), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .redirect(redirect), .redirectPc(redirectPc),
    .privMode(privMode)
  );

  task automatic idleInputs();
    curPc = '0; excValid = 0; excCode = '0; ecallValid = 0; sretValid = 0;
    irqReq = 0; irqCode = '0; csrValid = 0; csrWrite = 0; csrAddr = '0;
    csrWdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idleInputs();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic csrWr(input logic [11:0] a, input logic [31:0] d);
    csrValid = 1; csrWrite = 1; csrAddr = a; csrWdata = d;
    tick();
  endtask

  task automatic csrRd(input string req, input logic [11:0] a, input logic [31:0] exp);
    csrValid = 1; csrWrite = 0; csrAddr = a;
    #1 chk(req, csrRdata, exp);
    tick();
  endtask

  task automatic redirChk(input string req, input logic r, input logic [31:0] pc);
    #1 chk(req, {31'b0, redirect}, {31'b0, r});
    if (r) chk(req, redirectPc, pc);
  endtask

  task automatic modeChk(input string req, input logic m);
    chk(req, {31'b0, privMode}, {31'b0, m});
  endtask

  // go to user mode: epc and status set, then a legal return
  task automatic toUser(input logic [31:0] target);
    csrWr(A_EPC, target);
    csrWr(A_ST, 32'h20);
    sretValid = 1; curPc = 32'h1F00;
    redirChk("R4", 1'b1, target);
    tick();
    modeChk("R4", 1'b0);
    csrRd("R4", A_ST, 32'h22);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog all requirements act=timeout exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [6] = '{A_ST, A_VEC, A_SCR, A_EPC, A_CAU, A_BAD};
    logic [31:0] masks [6] = '{32'h122, 32'hFFFF_FFFC, 32'hFFFF_FFFF,
                               32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0};
    string       reqs  [6] = '{"R10", "R9", "R8", "R8", "R8", "R10"};
    logic [31:0] pats  [4] = '{32'hFFFF_FFFF, 32'h0, 32'hA5A5_A5A5, 32'h5A5A_5A5B};

    idleInputs();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R12 reset state
    modeChk("R12", 1'b1);
    #1 chk("R12", {31'b0, redirect}, 32'h0);
    for (int a = 0; a < 5; a++) csrRd("R12", addrs[a], 32'h0);

    // R8 R9 R10 register sweep
    for (int a = 0; a < 6; a++)
      for (int p = 0; p < 4; p++) begin
        csrWr(addrs[a], pats[p]);
        csrRd(reqs[a], addrs[a], pats[p] & masks[a]);
      end

    // R8 swap returns the old value and stores the new one
    csrWr(A_SCR, 32'h1234);
    csrValid = 1; csrWrite = 1; csrAddr = A_SCR; csrWdata = 32'h55;
    #1 chk("R8", csrRdata, 32'h1234);
    tick();
    csrRd("R8", A_SCR, 32'h55);

    // R4 legal return to user
    csrWr(A_VEC, 32'h1000);
    toUser(32'h2000);

    // R1 R2 R3 R11 call from user with a CSR write in the same cycle
    ecallValid = 1; curPc = 32'h2040;
    csrValid = 1; csrWrite = 1; csrAddr = A_SCR; csrWdata = 32'hDEAD;
    redirChk("R1", 1'b1, 32'h1000);
    tick();
    modeChk("R3", 1'b1);
    csrRd("R1", A_EPC, 32'h2040);
    csrRd("R2", A_CAU, 32'h8);
    csrRd("R3", A_ST, 32'h20);
    csrRd("R11", A_SCR, 32'h55);

    // R2 R3 call from supervisor
    ecallValid = 1; curPc = 32'h1010;
    redirChk("R1", 1'b1, 32'h1000);
    tick();
    csrRd("R2", A_CAU, 32'h9);
    csrRd("R3", A_ST, 32'h100);
    csrRd("R1", A_EPC, 32'h1010);

    // R2 other exception wins over a call
    excValid = 1; excCode = 4'd5; ecallValid = 1; curPc = 32'h1020;
    redirChk("R2", 1'b1, 32'h1000);
    tick();
    csrRd("R2", A_CAU, 32'h5);
    csrRd("R2", A_EPC, 32'h1020);

    // R5 return from user is illegal
    toUser(32'h3000);
    sretValid = 1; curPc = 32'h3004;
    redirChk("R5", 1'b1, 32'h1000);
    tick();
    modeChk("R5", 1'b1);
    csrRd("R5", A_CAU, 32'h2);
    csrRd("R5", A_EPC, 32'h3004);
    csrRd("R5", A_ST, 32'h20);

    // R6 interrupt taken in user mode
    toUser(32'h3008);
    irqReq = 1; irqCode = 4'd3; curPc = 32'h3010;
    redirChk("R6", 1'b1, 32'h1000);
    tick();
    modeChk("R6", 1'b1);
    csrRd("R6", A_CAU, 32'h8000_0003);
    csrRd("R6", A_EPC, 32'h3010);
    csrRd("R6", A_ST, 32'h20);

    // R7 interrupt held while disabled, then taken; R6 CSR write dropped
    irqReq = 1; irqCode = 4'd7; curPc = 32'h1100;
    redirChk("R7", 1'b0, 32'h0);
    tick();
    curPc = 32'h1104;
    redirChk("R7", 1'b0, 32'h0);
    tick();
    csrWr(A_ST, 32'h22);
    curPc = 32'h1108;
    csrValid = 1; csrWrite = 1; csrAddr = A_SCR; csrWdata = 32'hBEEF;
    redirChk("R7", 1'b1, 32'h1000);
    tick();
    csrRd("R7", A_CAU, 32'h8000_0007);
    csrRd("R6", A_EPC, 32'h1108);
    csrRd("R6", A_SCR, 32'h55);
    csrRd("R3", A_ST, 32'h120);

    // R7 interrupt coinciding with a call, then with a return
    toUser(32'h4000);
    ecallValid = 1; irqReq = 1; irqCode = 4'd1; curPc = 32'h4004;
    redirChk("R7", 1'b1, 32'h1000);
    tick();
    csrRd("R7", A_CAU, 32'h8);
    curPc = 32'h1200;
    redirChk("R7", 1'b0, 32'h0);
    tick();
    csrWr(A_EPC, 32'h4008);
    sretValid = 1; curPc = 32'h1204;
    redirChk("R7", 1'b1, 32'h4008);
    tick();
    modeChk("R7", 1'b0);
    curPc = 32'h4008;
    redirChk("R7", 1'b1, 32'h1000);
    tick();
    csrRd("R7", A_CAU, 32'h8000_0001);
    csrRd("R7", A_EPC, 32'h4008);
    curPc = 32'h1300;
    redirChk("R7", 1'b0, 32'h0);
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule